// File: doc/BRIEF.md
# SCL Clock Stretch and Synchronisation Controller

This block produces the clock line of a two-wire serial bus as an open-drain pull-down enable. While a transfer runs, it shapes the clock from two programmable phase lengths. It also follows the real line level through a synchroniser. The local high phase is timed only once the line is actually seen high, so any other device that holds the clock low slows this one down. If that device pulls the line low early, the block ends its own high phase and counts that edge as a completed bit.

Around each nine-clock byte the block can stretch the clock on its own. One control holds the line low from the falling edge of the eighth clock, which gives time to prepare an acknowledge. A second control holds the line low from the falling edge of the ninth clock, which gives time to inspect a received acknowledge. The second control takes effect only while delayed-clock mode is selected. A force-low control pulls the line down at any moment and takes priority over both the transfer clock and the release of a stretch. A status output shows when the block itself is holding a stretch. Data shifting, arbitration and interrupts belong to neighbouring logic.

Top module: `scl_wait_ctrl`

## Requirements
- R1: After reset, `scl_pull_low` and `stretching` are 0 and `scl_sync` is 1.
- R2: With no stretch and no other device active, each low phase lasts LOW_CYC cycles. Each high phase lasts HIGH_CYC + SYNC_STAGES + 1 cycles, because high timing begins only after the synchronised line reads 1.
- R3: With `wait_ack_gen` = 1, the line is held low from the falling edge that ends clock 8 of a byte, and `stretching` is 1 while that hold lasts. Clocks are counted from the first falling edge after `run` rises, which is number 0, and the count wraps from 9 to 1.
- R4: Clearing `wait_ack_gen` during that hold releases the line two cycles after the change, provided that `force_low` is 0.
- R5: With `delay_mode` = 1 and `wait_ack_chk` = 1, the line is held low from the falling edge that ends clock 9. Clearing `wait_ack_chk` releases it two cycles later.
- R6: With `delay_mode` = 0, `wait_ack_chk` has no effect. Clock 9 ends with a normal low phase and `stretching` stays 0.
- R7: `force_low` = 1 pulls the line low one cycle later and keeps it low for as long as it is set, also while a stretch is being released. The line is freed one cycle after `force_low` returns to 0.
- R8: If another device holds the line low for E cycles after a falling edge, the low phase as sampled lasts max(LOW_CYC, E+1) cycles. The high phase that follows still lasts HIGH_CYC + SYNC_STAGES + 1 cycles, or one cycle less when E >= LOW_CYC.
- R9: If another device pulls the line low during the local high phase, the block asserts `scl_pull_low` SYNC_STAGES + 1 cycles later and counts that edge as a falling clock edge.
- R10: With `run` = 0 the block releases the line within two cycles, even in the middle of a stretch. The clock count restarts at the next `run`.
- R11: `scl_sync` equals the line level delayed by SYNC_STAGES clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Transfer active; enables clock generation |
| force_low | input | 1 | Pull the line low unconditionally |
| wait_ack_gen | input | 1 | Stretch after clock 8 |
| wait_ack_chk | input | 1 | Stretch after clock 9 (requires delay_mode) |
| delay_mode | input | 1 | Delayed-clock mode select |
| scl_in | input | 1 | Raw clock line level |
| scl_pull_low | output | 1 | Open-drain pull-down enable (1 = drive low) |
| scl_sync | output | 1 | Synchronised line level |
| stretching | output | 1 | Block is holding a clock stretch |

## Verification
The hardest situations to reach are the ones where the line disagrees with the block's own intent. Examples are another device that keeps the line low past the local low count, a pull-down that arrives in the middle of the local high phase, and a forced low that overlaps the release of a stretch. The bench models the other device as an extra open-drain pull on the line. Random stretch lengths are injected just after falling edges, both shorter and longer than the local low count. A directed pull is timed into the high phase, and force is applied while a hold is in progress. Random per-byte control settings cover every combination of the two hold points and delayed-clock mode.

// File: rtl/scl_ws_pkg.sv
package scl_ws_pkg;

    localparam logic [3:0] ACK_GEN_BIT = 4'd8;
    localparam logic [3:0] ACK_CHK_BIT = 4'd9;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOW,
        PH_REL,
        PH_HIGH,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        HK_NONE,
        HK_ACKGEN,
        HK_ACKCHK
    } hold_e;

    typedef struct packed {
        logic wait_gen;
        logic wait_chk;
        logic delayed;
    } hold_ctl_t;

    typedef struct packed {
        logic      run;
        logic      force_low;
        hold_ctl_t hold;
    } scl_ctl_t;

    function automatic logic [3:0] next_bit(input logic [3:0] cur);
        return (cur >= ACK_CHK_BIT) ? 4'd1 : cur + 4'd1;
    endfunction

    function automatic hold_e hold_at(input logic [3:0] nb, input hold_ctl_t c);
        if (nb == ACK_GEN_BIT && c.wait_gen)
            return HK_ACKGEN;
        if (nb == ACK_CHK_BIT && c.wait_chk && c.delayed)
            return HK_ACKCHK;
        return HK_NONE;
    endfunction

    function automatic logic hold_keep(input hold_e k, input hold_ctl_t c);
        case (k)
            HK_ACKGEN: return c.wait_gen;
            HK_ACKCHK: return c.wait_chk && c.delayed;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/scl_ws_sync.sv
module scl_ws_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= RST_VAL;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scl_ws_bitpos.sv
module scl_ws_bitpos
    import scl_ws_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       advance,
    output logic [3:0] bit_idx
);
    always_ff @(posedge clk) begin
        if (rst || clear)  bit_idx <= 4'd0;
        else if (advance)  bit_idx <= next_bit(bit_idx);
    end

    AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        bit_idx <= ACK_CHK_BIT); // R3

    AST_BIT_RESTART: assert property (@(posedge clk) disable iff (rst)
        clear |=> bit_idx == 4'd0); // R10
endmodule

// File: rtl/scl_ws_phase.sv
module scl_ws_phase
    import scl_ws_pkg::*;
#(
    parameter int LOW_CYC  = 5,
    parameter int HIGH_CYC = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  hold_ctl_t  hctl,
    input  logic       scl_hi,
    input  logic [3:0] bit_idx,
    output logic       fall_evt,
    output logic       phase_pull,
    output logic       hold_active
);
    localparam int CNT_MAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LOW_LOAD  = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] HIGH_LOAD = CNT_W'(HIGH_CYC - 1);

    phase_e           st, st_n;
    hold_e            kind, kind_n, kind_new;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        kind_n   = kind;
        fall_evt = 1'b0;
        kind_new = HK_NONE;
        if (!run) begin
            st_n   = PH_IDLE;
            kind_n = HK_NONE;
        end else begin
            case (st)
                PH_IDLE: begin
                    st_n  = PH_LOW;
                    cnt_n = LOW_LOAD;
                end
                PH_LOW: begin
                    if (cnt == '0) st_n = PH_REL;
                    else           cnt_n = cnt - 1'b1;
                end
                PH_REL: begin
                    if (scl_hi) begin
                        st_n  = PH_HIGH;
                        cnt_n = HIGH_LOAD;
                    end
                end
                PH_HIGH: begin
                    if (!scl_hi || cnt == '0) begin
                        fall_evt = 1'b1;
                        kind_new = hold_at(next_bit(bit_idx), hctl);
                        if (kind_new != HK_NONE) begin
                            st_n   = PH_HOLD;
                            kind_n = kind_new;
                        end else begin
                            st_n  = PH_LOW;
                            cnt_n = LOW_LOAD;
                        end
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (!hold_keep(kind, hctl) && !scl_hi) begin
                        st_n   = PH_REL;
                        kind_n = HK_NONE;
                    end
                end
                default: st_n = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= PH_IDLE;
            cnt  <= '0;
            kind <= HK_NONE;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            kind <= kind_n;
        end
    end

    assign phase_pull  = (st == PH_LOW) || (st == PH_HOLD);
    assign hold_active = (st == PH_HOLD);

    AST_HIGH_AFTER_SEEN: assert property (@(posedge clk) disable iff (rst)
        $rose(st == PH_HIGH) |-> $past(scl_hi)); // R8

    AST_HOLD_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_active) |-> $past(fall_evt)); // R3

    AST_CHK_NEEDS_DELAY: assert property (@(posedge clk) disable iff (rst)
        (st == PH_HOLD && kind == HK_ACKCHK) |-> $past(hctl.wait_chk && hctl.delayed)); // R5

    AST_GEN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (run && st == PH_HOLD && kind == HK_ACKGEN && !hctl.wait_gen && !scl_hi)
        |=> st == PH_REL); // R4

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !run |=> !phase_pull); // R10
endmodule

// File: rtl/scl_wait_ctrl.sv
module scl_wait_ctrl
    import scl_ws_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_CYC     = 5,
    parameter int HIGH_CYC    = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic force_low,
    input  logic wait_ack_gen,
    input  logic wait_ack_chk,
    input  logic delay_mode,
    input  logic scl_in,
    output logic scl_pull_low,
    output logic scl_sync,
    output logic stretching
);
    scl_ctl_t   ctl_q;
    logic       scl_s;
    logic [3:0] bit_idx;
    logic       fall_evt;
    logic       phase_pull;
    logic       hold_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q.run           <= run;
            ctl_q.force_low     <= force_low;
            ctl_q.hold.wait_gen <= wait_ack_gen;
            ctl_q.hold.wait_chk <= wait_ack_chk;
            ctl_q.hold.delayed  <= delay_mode;
        end
    end

    scl_ws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (scl_in),
        .q   (scl_s)
    );

    scl_ws_bitpos u_bitpos (
        .clk     (clk),
        .rst     (rst),
        .clear   (!ctl_q.run),
        .advance (fall_evt),
        .bit_idx (bit_idx)
    );

    scl_ws_phase #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .run         (ctl_q.run),
        .hctl        (ctl_q.hold),
        .scl_hi      (scl_s),
        .bit_idx     (bit_idx),
        .fall_evt    (fall_evt),
        .phase_pull  (phase_pull),
        .hold_active (hold_active)
    );

    assign scl_pull_low = ctl_q.force_low | phase_pull;
    assign scl_sync     = scl_s;
    assign stretching   = hold_active;

    AST_STRETCH_PULLS: assert property (@(posedge clk) disable iff (rst)
        stretching |-> scl_pull_low); // R3

    AST_FORCE_WINS: assert property (@(posedge clk) disable iff (rst)
        $rose(force_low) |=> scl_pull_low); // R7

    AST_RESET_FREE: assert property (@(posedge clk)
        $past(rst) |-> !stretching); // R1
endmodule

// File: tb/tb_scl_wait_ctrl.sv
`timescale 1ns/1ps
module tb_scl_wait_ctrl;
    localparam int SYNC  = 2;
    localparam int LOWC  = 5;
    localparam int HIGHC = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0, force_low = 1'b0;
    logic wait8 = 1'b0, wait9 = 1'b0, dmode = 1'b0;
    logic ext_pull = 1'b0;
    logic scl_pull_low, scl_sync, stretching;
    wire  scl_line = !(scl_pull_low || ext_pull);

    int vec = 0, bad = 0, cyc = 0;
    int mon_valid = 0;
    logic [SYNC-1:0] hist;

    always #2 clk = ~clk;

    scl_wait_ctrl #(.SYNC_STAGES(SYNC), .LOW_CYC(LOWC), .HIGH_CYC(HIGHC)) dut (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .force_low    (force_low),
        .wait_ack_gen (wait8),
        .wait_ack_chk (wait9),
        .delay_mode   (dmode),
        .scl_in       (scl_line),
        .scl_pull_low (scl_pull_low),
        .scl_sync     (scl_sync),
        .stretching   (stretching)
    );

    function automatic int exp_low(input int e);
        if (e == 0) return LOWC;
        return (e + 1 > LOWC) ? e + 1 : LOWC;
    endfunction

    function automatic int exp_high(input int e);
        return (e >= LOWC) ? HIGHC + SYNC : HIGHC + SYNC + 1;
    endfunction

    function automatic logic exp_hold(input int b, input logic w8, input logic w9, input logic cd);
        return (b == 8 && w8) || (b == 9 && w9 && cd);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // R11: line level seen just before each rising edge, compared two cycles later
    always @(negedge clk) begin
        #1;
        if (rst) begin
            mon_valid = 0;
        end else begin
            if (mon_valid >= SYNC)
                chk(scl_sync == hist[SYNC-1], "R11", scl_sync, hist[SYNC-1]);
            hist = {hist[SYNC-2:0], scl_line};
            if (mon_valid < SYNC) mon_valid++;
        end
    end

    task automatic wait_low();
        while (scl_line) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_line) @(negedge clk);
    endtask

    // Entered at the negedge where a falling edge is first seen; returns at the next one.
    task automatic do_fall(input int b, input int e, input int hw);
        logic h;
        int ll, hl, j;
        logic lv, good;
        string req;
        h = exp_hold(b, wait8, wait9, dmode);
        if (h) begin
            req = (b == 8) ? "R3" : "R5";
            chk(stretching == 1'b1, req, stretching, 1);
            good = 1'b1;
            repeat (hw) begin
                @(negedge clk);
                if (scl_line || !stretching) good = 1'b0;
            end
            chk(good, req, scl_line, 0);
            if (b == 8) wait8 = 1'b0;
            else        wait9 = 1'b0;
            repeat (2) @(negedge clk);
            chk(scl_line == 1'b1 && !stretching, (b == 8) ? "R4" : "R5", scl_line, 1);
            hl = 1;
            forever begin
                @(negedge clk);
                if (scl_line) hl++;
                else break;
            end
            chk(hl == exp_high(0), "R2", hl, exp_high(0));
        end else begin
            req = (b == 9 && wait9 && !dmode) ? "R6" : "R3";
            chk(stretching == 1'b0, req, stretching, 0);
            if (e > 0) ext_pull = 1'b1;
            ll = 1;
            j  = 0;
            forever begin
                @(negedge clk);
                j++;
                lv = scl_line;
                if (ext_pull && j == e) ext_pull = 1'b0;
                if (lv) break;
                ll++;
            end
            chk(ll == exp_low(e), (e > 0) ? "R8" : "R2", ll, exp_low(e));
            hl = 1;
            forever begin
                @(negedge clk);
                if (scl_line) hl++;
                else break;
            end
            chk(hl == exp_high(e), (e > 0) ? "R8" : "R2", hl, exp_high(e));
        end
    endtask

    initial begin
        int k;
        logic good;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(scl_pull_low == 1'b0, "R1", scl_pull_low, 0);
        chk(stretching == 1'b0, "R1", stretching, 0);
        chk(scl_sync == 1'b1, "R1", scl_sync, 1);

        // Hold after clock 8, none after 9
        wait8 = 1'b1;
        run = 1'b1;
        wait_low();
        for (int b = 0; b <= 9; b++) do_fall(b, 0, 4);
        run = 1'b0;
        repeat (3) @(negedge clk);
        chk(scl_line == 1'b1, "R10", scl_line, 1);

        // Another device pulls during the local high phase
        run = 1'b1;
        wait_low();
        wait_high();
        repeat (4) @(negedge clk);
        ext_pull = 1'b1;
        k = 0;
        while (!scl_pull_low && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk(k == SYNC + 1, "R9", k, SYNC + 1);
        ext_pull = 1'b0;

        // Force low during the high phase
        wait_high();
        repeat (4) @(negedge clk);
        force_low = 1'b1;
        @(negedge clk);
        chk(scl_pull_low == 1'b1, "R7", scl_pull_low, 1);
        good = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (scl_line) good = 1'b0;
        end
        chk(good, "R7", scl_line, 0);
        force_low = 1'b0;
        run = 1'b0;
        repeat (4) @(negedge clk);

        // Force outranks the release of a stretch
        wait8 = 1'b1;
        run = 1'b1;
        wait_low();
        for (int b = 0; b <= 7; b++) do_fall(b, 0, 4);
        chk(stretching == 1'b1, "R3", stretching, 1);
        force_low = 1'b1;
        repeat (2) @(negedge clk);
        wait8 = 1'b0;
        repeat (5) @(negedge clk);
        chk(scl_line == 1'b0, "R7", scl_line, 0);
        force_low = 1'b0;
        @(negedge clk);
        chk(scl_line == 1'b1, "R7", scl_line, 1);
        run = 1'b0;
        repeat (4) @(negedge clk);

        // Dropping run in the middle of a stretch, then counting restarts
        wait8 = 1'b1;
        run = 1'b1;
        wait_low();
        for (int b = 0; b <= 7; b++) do_fall(b, 0, 4);
        chk(stretching == 1'b1, "R3", stretching, 1);
        run = 1'b0;
        repeat (2) @(negedge clk);
        chk(scl_line == 1'b1 && !stretching, "R10", scl_line, 1);
        wait9 = 1'b1;
        dmode = 1'b1;
        run = 1'b1;
        wait_low();
        for (int b = 0; b <= 9; b++) do_fall(b, 0, 4);

        // Random bytes
        for (int byte_n = 0; byte_n < 30; byte_n++) begin
            if (byte_n == 0) begin
                wait8 = $urandom % 2;
                wait9 = 1'b1;
                dmode = 1'b0;
            end else begin
                wait8 = $urandom % 2;
                wait9 = $urandom % 2;
                dmode = $urandom % 2;
            end
            for (int b = 1; b <= 9; b++) begin
                int e;
                int hw;
                e  = 0;
                hw = 3 + ($urandom % 6);
                if (!exp_hold(b, wait8, wait9, dmode) && ($urandom % 3 == 0))
                    e = 1 + ($urandom % (LOWC + 4));
                do_fall(b, e, hw);
            end
        end
        run = 1'b0;
        repeat (4) @(negedge clk);
        chk(scl_line == 1'b1, "R10", scl_line, 1);
        finish_run();
    end
endmodule